// File: doc/BRIEF.md
# Write-once real-time clock source selector

This block chooses the clock that drives a real-time counter. There are three candidate sources: a fast crystal clock, which the block divides by a fixed ratio of 32 itself, a low-speed crystal clock, and a low-speed internal RC clock. Software writes a 2-bit code through a simple bus-clocked write port. The first nonzero code written is taken and then frozen.

Only a dedicated backup-domain reset can release that choice. An ordinary system reset does not touch it. A read-back port returns the current code and a lock flag.

Each source is switched onto the output through its own gate. The gate's enable passes through a synchronizer clocked on that source's falling edge, so the selected clock starts with a clean, full-width high phase. The bus clock is assumed to run at least as fast as the selected real-time clock.

Top module: `rtc_clk_select`

## Requirements
- R1: While and after the backup-domain reset, the read-back code is 00, the lock flag is 0 and `rtc_clk` is held low.
- R2: The first write of a nonzero code while unlocked is loaded and sets the lock flag. It is visible on the read-back port from the bus clock edge that samples the write. The code map is: 01 selects the low-speed crystal, 10 the internal RC clock, and 11 the fast crystal divided by 32.
- R3: Once the lock flag is set, writes of any code leave the read-back code and the lock flag unchanged until the next backup-domain reset.
- R4: Writing 00 while unlocked leaves the code at 00 and the lock flag at 0, and `rtc_clk` stays low.
- R5: Asserting the system reset clears neither the code nor the lock flag. A write presented while the system reset is asserted is ignored.
- R6: The fast path divides the fast crystal clock by exactly 32 with a 50% duty cycle, that is, 16 fast cycles high and 16 low.
- R7: Once a source is selected, `rtc_clk` has that source's period and high time. At most one source gate is ever enabled.
- R8: The gated output starts without a runt pulse. Its first rising edge after selection is followed by a full-width high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| sys_rst_n | input | 1 | System reset, active low; blocks writes only |
| bkp_rst_n | input | 1 | Backup-domain reset, active low; clears code and lock |
| wr_en | input | 1 | Write strobe for the selection code |
| wr_code | input | 2 | Selection code to write |
| fast_clk | input | 1 | Fast crystal clock, divided by 32 internally |
| lse_clk | input | 1 | Low-speed crystal clock |
| lsi_clk | input | 1 | Low-speed internal RC clock |
| rtc_clk | output | 1 | Selected, gated real-time clock |
| rd_code | output | 2 | Current selection code |
| rd_locked | output | 1 | Lock flag |

## Verification
On every cycle the assertions check four things: the lock and the frozen code hold in the bus domain, an unlocked nonzero write is taken, at most one gate enable is active, and each divider half-period is exactly 16 fast cycles. The bench's scenarios show the rest. It checks the output period and first-pulse width of each source, and confirms that zero writes and writes during system reset are ignored. It also checks that a system reset leaves the selection alone while a domain reset clears it. It sweeps every first code against every second code.

// File: rtl/rtcsel_pkg.sv
`timescale 1ns/1ps
package rtcsel_pkg;
   localparam int CODE_W  = 2;
   localparam int NUM_SRC = 3;
   typedef enum logic [CODE_W-1:0] {
      SRC_NONE = 2'b00,
      SRC_XTAL = 2'b01,
      SRC_RC   = 2'b10,
      SRC_FAST = 2'b11
   } src_code_e;
endpackage

// File: rtl/rtcsel_div.sv
`timescale 1ns/1ps
module rtcsel_div #(
   parameter int RATIO = 32
) (
   input  logic clk_in,
   input  logic rst_n,
   output logic clk_out
);
   localparam int HALF  = RATIO / 2;
   localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int POW2  = ((RATIO & (RATIO - 1)) == 0) ? 1 : 0;

   if (RATIO < 2 || (RATIO % 2) != 0) begin : g_bad_ratio
      $error("rtcsel_div: RATIO must be even and at least 2");
   end

   if (POW2 == 1) begin : g_pow2
      localparam int FW = $clog2(RATIO);
      logic [FW-1:0] free_cnt;
      always_ff @(posedge clk_in or negedge rst_n) begin
         if (!rst_n) free_cnt <= '0;
         else        free_cnt <= free_cnt + 1'b1;
      end
      assign clk_out = free_cnt[FW-1];
   end else begin : g_toggle
      logic [CNT_W-1:0] half_cnt;
      logic             tog;
      always_ff @(posedge clk_in or negedge rst_n) begin
         if (!rst_n) begin
            half_cnt <= '0;
            tog      <= 1'b0;
         end else if (half_cnt == CNT_W'(HALF - 1)) begin
            half_cnt <= '0;
            tog      <= ~tog;
         end else begin
            half_cnt <= half_cnt + 1'b1;
         end
      end
      assign clk_out = tog;
   end

   // checker: fast cycles between output changes
   logic [CNT_W:0] chk_run;
   logic           chk_prev;
   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         chk_run  <= '0;
         chk_prev <= 1'b0;
      end else begin
         chk_prev <= clk_out;
         if (clk_out != chk_prev) chk_run <= (CNT_W+1)'(1);
         else                     chk_run <= chk_run + 1'b1;
      end
   end

   AST_DIV_HALF_PERIOD: assert property (@(posedge clk_in) disable iff (!rst_n)
      (clk_out != chk_prev) |-> (chk_run == (CNT_W+1)'(HALF))); // R6
endmodule

// File: rtl/rtcsel_reg.sv
`timescale 1ns/1ps
module rtcsel_reg
   import rtcsel_pkg::*;
(
   input  logic              bus_clk,
   input  logic              sys_rst_n,
   input  logic              bkp_rst_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_code,
   output logic [CODE_W-1:0] code,
   output logic              locked
);
   logic take;
   assign take = wr_en && sys_rst_n && !locked && (wr_code != SRC_NONE);

   always_ff @(posedge bus_clk or negedge bkp_rst_n) begin
      if (!bkp_rst_n) begin
         code   <= SRC_NONE;
         locked <= 1'b0;
      end else if (take) begin
         code   <= wr_code;
         locked <= 1'b1;
      end
   end

   AST_LOCK_HOLDS: assert property (@(posedge bus_clk) disable iff (!bkp_rst_n)
      locked |=> locked); // R3
   AST_CODE_FROZEN: assert property (@(posedge bus_clk) disable iff (!bkp_rst_n)
      locked |=> $stable(code)); // R3
   AST_FIRST_WRITE_TAKEN: assert property (@(posedge bus_clk) disable iff (!bkp_rst_n)
      (!locked && wr_en && sys_rst_n && wr_code != 2'b00) |=> (locked && code == $past(wr_code))); // R2
   AST_ZERO_NO_LOCK: assert property (@(posedge bus_clk) disable iff (!bkp_rst_n)
      (!locked && !(wr_en && sys_rst_n && wr_code != 2'b00)) |=> !locked); // R4
endmodule

// File: rtl/rtcsel_gate.sv
`timescale 1ns/1ps
module rtcsel_gate #(
   parameter int SYNC_STAGES = 2
) (
   input  logic src_clk,
   input  logic rst_n,
   input  logic en_req,
   output logic en_live,
   output logic gclk
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rtcsel_gate: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] shift;
   always_ff @(negedge src_clk or negedge rst_n) begin
      if (!rst_n) shift <= '0;
      else        shift <= {shift[SYNC_STAGES-2:0], en_req};
   end

   assign en_live = shift[SYNC_STAGES-1];
   assign gclk    = src_clk & en_live;
endmodule

// File: rtl/rtc_clk_select.sv
`timescale 1ns/1ps
module rtc_clk_select
   import rtcsel_pkg::*;
#(
   parameter int FAST_DIV    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic        bus_clk,
   input  logic        sys_rst_n,
   input  logic        bkp_rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_code,
   input  logic        fast_clk,
   input  logic        lse_clk,
   input  logic        lsi_clk,
   output logic        rtc_clk,
   output logic [1:0]  rd_code,
   output logic        rd_locked
);
   logic [CODE_W-1:0]  code;
   logic               locked;
   logic               fast_div_clk;
   logic [NUM_SRC-1:0] src_vec;
   logic [NUM_SRC-1:0] en_req;
   logic [NUM_SRC-1:0] en_live;
   logic [NUM_SRC-1:0] gclk;

   rtcsel_reg u_reg (
      .bus_clk   (bus_clk),
      .sys_rst_n (sys_rst_n),
      .bkp_rst_n (bkp_rst_n),
      .wr_en     (wr_en),
      .wr_code   (wr_code),
      .code      (code),
      .locked    (locked)
   );

   rtcsel_div #(.RATIO(FAST_DIV)) u_div (
      .clk_in  (fast_clk),
      .rst_n   (bkp_rst_n),
      .clk_out (fast_div_clk)
   );

   // index i serves code i+1
   assign src_vec = {fast_div_clk, lsi_clk, lse_clk};

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign en_req[i] = (code == CODE_W'(i + 1));
      rtcsel_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
         .src_clk (src_vec[i]),
         .rst_n   (bkp_rst_n),
         .en_req  (en_req[i]),
         .en_live (en_live[i]),
         .gclk    (gclk[i])
      );
   end

   assign rtc_clk   = |gclk;
   assign rd_code   = code;
   assign rd_locked = locked;

   AST_ONE_GATE: assert property (@(posedge bus_clk) disable iff (!bkp_rst_n)
      $onehot0(en_live)); // R7
   AST_IDLE_LOW: assert property (@(posedge bus_clk) disable iff (!bkp_rst_n)
      (!locked && en_live == '0) |-> !rtc_clk); // R1
endmodule

// File: tb/tb_rtc_clk_select.sv
`timescale 1ns/1ps
module tb_rtc_clk_select;
   logic bus_clk = 0, fast_clk = 0, lse_clk = 0, lsi_clk = 0;
   logic sys_rst_n, bkp_rst_n, wr_en;
   logic [1:0] wr_code;
   logic rtc_clk;
   logic [1:0] rd_code;
   logic rd_locked;
   int n_run = 0, n_fail = 0;

   always #2  bus_clk  = ~bus_clk;   // 250 MHz
   always #5  fast_clk = ~fast_clk;  // 10 ns
   always #20 lse_clk  = ~lse_clk;   // 40 ns
   always #28 lsi_clk  = ~lsi_clk;   // 56 ns

   rtc_clk_select dut (
      .bus_clk(bus_clk), .sys_rst_n(sys_rst_n), .bkp_rst_n(bkp_rst_n),
      .wr_en(wr_en), .wr_code(wr_code), .fast_clk(fast_clk),
      .lse_clk(lse_clk), .lsi_clk(lsi_clk), .rtc_clk(rtc_clk),
      .rd_code(rd_code), .rd_locked(rd_locked)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic bkp_reset();
      @(negedge bus_clk); bkp_rst_n = 0;
      repeat (3) @(negedge bus_clk);
      bkp_rst_n = 1;
      @(negedge bus_clk);
   endtask

   task automatic write(input logic [1:0] c);
      @(negedge bus_clk); wr_en = 1; wr_code = c;
      @(negedge bus_clk); wr_en = 0;
   endtask

   task automatic check_low(input string req);
      int highs = 0;
      for (int k = 0; k < 100; k++) begin
         #7; if (rtc_clk) highs++;
      end
      chk(highs == 0, req, "rtc_clk stays low (high samples)", highs, 0);
   endtask

   // first pulse after selection: high time, then period
   task automatic measure(input string req, input int exp_per);
      realtime t0, t1, t2;
      @(posedge rtc_clk); t0 = $realtime;
      @(negedge rtc_clk); t1 = $realtime;
      @(posedge rtc_clk); t2 = $realtime;
      chk($rtoi(t1 - t0) == exp_per / 2, "R8", "first high phase ns",
          $rtoi(t1 - t0), exp_per / 2);
      chk($rtoi(t2 - t0) == exp_per, req, "period ns", $rtoi(t2 - t0), exp_per);
      @(negedge rtc_clk); t1 = $realtime;
      chk($rtoi(t1 - t2) == exp_per / 2, req, "steady high ns",
          $rtoi(t1 - t2), exp_per / 2);
   endtask

   function automatic int period_of(input int c);
      case (c)
         1: return 40;
         2: return 56;
         default: return 10 * 32;
      endcase
   endfunction

   initial begin
      #2000000;
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      sys_rst_n = 0; bkp_rst_n = 0; wr_en = 0; wr_code = 0;
      repeat (4) @(negedge bus_clk);
      sys_rst_n = 1; bkp_rst_n = 1;
      @(negedge bus_clk);
      chk(rd_code == 0, "R1", "code after reset", rd_code, 0);
      chk(rd_locked == 0, "R1", "lock after reset", rd_locked, 0);
      check_low("R1");

      // R4: zero write while unlocked
      write(2'b00);
      chk(rd_code == 0 && rd_locked == 0, "R4", "code/lock after 00 write",
          {rd_locked, rd_code}, 0);
      check_low("R4");

      // R5: write during system reset ignored
      @(negedge bus_clk); sys_rst_n = 0;
      write(2'b10);
      @(negedge bus_clk); sys_rst_n = 1;
      chk(rd_code == 0 && rd_locked == 0, "R5", "write in sys reset ignored",
          {rd_locked, rd_code}, 0);

      // sweep first code x second code
      for (int c = 1; c < 4; c++) begin
         bkp_reset();
         chk(rd_code == 0 && rd_locked == 0, "R1", "domain reset clears",
             {rd_locked, rd_code}, 0);
         write(c[1:0]);
         chk(rd_code == c[1:0], "R2", "code loaded", rd_code, c);
         chk(rd_locked == 1, "R2", "lock set", rd_locked, 1);
         for (int d = 0; d < 4; d++) begin
            write(d[1:0]);
            chk(rd_code == c[1:0] && rd_locked, "R3", "second write ignored",
                {rd_locked, rd_code}, 4 + c);
         end
         measure(c == 3 ? "R6" : "R7", period_of(c));
         @(negedge bus_clk); sys_rst_n = 0;
         repeat (3) @(negedge bus_clk); sys_rst_n = 1;
         @(negedge bus_clk);
         chk(rd_code == c[1:0] && rd_locked, "R5", "sys reset keeps selection",
             {rd_locked, rd_code}, 4 + c);
         measure("R7", period_of(c));
      end

      bkp_reset();
      chk(rd_code == 0 && rd_locked == 0, "R1", "final domain reset",
          {rd_locked, rd_code}, 0);
      check_low("R1");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule